// File: doc/BRIEF.md
# Vectored Two-Path Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and presents them to a processor on two request lines: a normal line and a fast line. Each source carries an enable bit, a routing bit that sends it to one line or the other, and a 4-bit priority. Software reaches all of this through a small 32-bit register bus with byte addresses. Each 64-bit per-source quantity is split across two words. The word for sources 32..63 sits at the lower of its two addresses.

For each path the block forms a pending word from the raw inputs, the software force bits and the enables. It also forms a vector word whose upper half names the winning source. On the normal path the winner is chosen by priority and gated by a programmable mask level. On the fast path the highest-numbered pending source wins. A handler masks or acknowledges a source by clearing its enable bit, either through the enable words or through the set/clear-by-number registers. A level input stays pending for as long as it is asserted.

Top module: `vec_intc`

## Requirements
- R1: After reset the control word reads 0, the mask level reads 0x1F, and every enable, routing, force and priority bit reads 0. Both request lines are low and both vector words read 0xFFFF0000.
- R2: A source's effective request is (input OR force bit) AND enable bit. Effective requests whose routing bit is 0 appear in the normal pending words (0x58 for sources 32..63, 0x5C for 0..31). Those whose routing bit is 1 appear in the fast pending words (0x60 high, 0x64 low). Enable words are at 0x10/0x14, routing words at 0x18/0x1C and force words at 0x50/0x54, high word first in each pair.
- R3: The raw-input words at 0x48 (high) and 0x4C (low) read the source inputs unchanged, whatever the enable, force and routing bits are.
- R4: Writing a value n below 64 to 0x08 sets enable bit n, and writing n to 0x0C clears it. Any value of 64 or more written to either address leaves every enable bit unchanged. Both addresses read 0.
- R5: Priority register x (0..7) sits at byte address 0x20 + 4*(7-x). Its bits [4k+3:4k] hold the priority of source 8x+k.
- R6: Bits [31:16] of the normal vector word (0x40) hold the number of the normal pending source with the highest priority, with ties going to the higher source number. They read 0xFFFF when no normal source is pending. Bits [15:0] read 0.
- R7: The mask level register at 0x04 holds 5 bits. When its bit 4 is 1, no normal source is filtered. Otherwise a normal source counts as pending, in the pending words, the vector and the request line, only when its priority is strictly greater than bits [3:0].
- R8: Bits [31:16] of the fast vector word (0x44) hold the highest-numbered fast pending source, or 0xFFFF when none is pending. Bits [15:0] read 0.
- R9: The normal request line is high exactly when some normal source is pending. The fast request line is high exactly when some fast source is pending.
- R10: A register write takes effect at the clock edge that ends the write cycle. Reads and both request lines reflect the current register contents and inputs within the same cycle.
- R11: The control word at 0x00 stores and returns all 32 bits written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_i | input | 64 | Level-sensitive source inputs |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
Two things can land in the same cycle: a bus write that changes a source's enable, force, routing or priority, and a change on the raw input of that same or a competing source. The bench drives both at one falling edge many times, in random order with random data. After each edge it recomputes the pending words, both vectors and both request lines from its own shadow of the registers, and compares them with what the block reads back. One directed case clears the current normal winner by number. It checks that the request line keeps its old value until the edge and takes the new one right after it.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam logic [6:0] A_CTL    = 7'h00;
  localparam logic [6:0] A_LVL    = 7'h04;
  localparam logic [6:0] A_SETNUM = 7'h08;
  localparam logic [6:0] A_CLRNUM = 7'h0C;
  localparam logic [6:0] A_ENH    = 7'h10;
  localparam logic [6:0] A_ENL    = 7'h14;
  localparam logic [6:0] A_TYH    = 7'h18;
  localparam logic [6:0] A_TYL    = 7'h1C;
  localparam logic [6:0] A_PRI0   = 7'h20;
  localparam logic [6:0] A_PRIN   = 7'h3C;
  localparam logic [6:0] A_NVEC   = 7'h40;
  localparam logic [6:0] A_FVEC   = 7'h44;
  localparam logic [6:0] A_RAWH   = 7'h48;
  localparam logic [6:0] A_RAWL   = 7'h4C;
  localparam logic [6:0] A_FRCH   = 7'h50;
  localparam logic [6:0] A_FRCL   = 7'h54;
  localparam logic [6:0] A_NPH    = 7'h58;
  localparam logic [6:0] A_NPL    = 7'h5C;
  localparam logic [6:0] A_FPH    = 7'h60;
  localparam logic [6:0] A_FPL    = 7'h64;

  typedef enum logic { PICK_BY_PRIO, PICK_BY_INDEX } pick_mode_e;

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] wdata;
  } bus_req_t;

endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
  import vec_intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 4,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_req_t             req,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC-1:0]      ty_q,
  output logic [NSRC-1:0]      fr_q,
  output logic [NSRC*PW-1:0]   pr_q,
  output logic [PW:0]          lvl_q,
  output logic [DW-1:0]        ctl_q
);
  localparam int IW  = $clog2(NSRC);
  localparam int NPR = NSRC * PW / DW;
  localparam int PRW = $clog2(NPR);

  logic                we;
  logic [NSRC-1:0]     en_d, ty_d, fr_d;
  logic [NSRC*PW-1:0]  pr_d;
  logic [PW:0]         lvl_d;
  logic [DW-1:0]       ctl_d;
  logic [6:0]          pr_off;
  logic [PRW-1:0]      pr_x;
  logic                num_ok;

  assign we     = req.sel & req.wr;
  assign pr_off = req.addr - A_PRI0;
  assign pr_x   = PRW'(NPR - 1) - pr_off[PRW+1:2];
  assign num_ok = (req.wdata < NSRC);

  // next state
  always_comb begin
    en_d  = en_q;
    ty_d  = ty_q;
    fr_d  = fr_q;
    pr_d  = pr_q;
    lvl_d = lvl_q;
    ctl_d = ctl_q;
    case (req.addr)
      A_CTL:    ctl_d = req.wdata;
      A_LVL:    lvl_d = req.wdata[PW:0];
      A_SETNUM: if (num_ok) en_d[req.wdata[IW-1:0]] = 1'b1;
      A_CLRNUM: if (num_ok) en_d[req.wdata[IW-1:0]] = 1'b0;
      A_ENH:    en_d[DW +: DW] = req.wdata;
      A_ENL:    en_d[0  +: DW] = req.wdata;
      A_TYH:    ty_d[DW +: DW] = req.wdata;
      A_TYL:    ty_d[0  +: DW] = req.wdata;
      A_FRCH:   fr_d[DW +: DW] = req.wdata;
      A_FRCL:   fr_d[0  +: DW] = req.wdata;
      default: begin
        if (req.addr >= A_PRI0 && req.addr <= A_PRIN && req.addr[1:0] == 2'b00)
          pr_d[pr_x*DW +: DW] = req.wdata;
      end
    endcase
  end

  // registers with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ty_q  <= '0;
      fr_q  <= '0;
      pr_q  <= '0;
      lvl_q <= '1;
      ctl_q <= '0;
    end else if (we) begin
      en_q  <= en_d;
      ty_q  <= ty_d;
      fr_q  <= fr_d;
      pr_q  <= pr_d;
      lvl_q <= lvl_d;
      ctl_q <= ctl_d;
    end
  end

  a_r4_set_by_num: assert property (@(posedge clk) disable iff (!rst_n)
    (we && req.addr == A_SETNUM && req.wdata < NSRC) |=> en_q[$past(req.wdata[IW-1:0])]);

  a_r4_clr_by_num: assert property (@(posedge clk) disable iff (!rst_n)
    (we && req.addr == A_CLRNUM && req.wdata < NSRC) |=> !en_q[$past(req.wdata[IW-1:0])]);

  a_r4_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (req.addr == A_SETNUM || req.addr == A_CLRNUM) && req.wdata >= NSRC) |=> $stable(en_q));

  a_r10_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(en_q) && $stable(ty_q) && $stable(pr_q) && $stable(lvl_q)));

endmodule

// File: rtl/vec_intc_pick.sv
module vec_intc_pick
  import vec_intc_pkg::*;
#(
  parameter int         NSRC = 64,
  parameter int         PW   = 4,
  parameter pick_mode_e MODE = PICK_BY_PRIO
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           req,
  input  logic [NSRC*PW-1:0]        pri,
  output logic                      hit,
  output logic [$clog2(NSRC)-1:0]   idx
);
  localparam int IW = $clog2(NSRC);

  generate
    if (MODE == PICK_BY_PRIO) begin : g_prio
      logic [PW-1:0] best;
      always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
          if (req[i] && (!hit || pri[i*PW +: PW] >= best)) begin
            hit  = 1'b1;
            idx  = IW'(i);
            best = pri[i*PW +: PW];
          end
        end
      end
    end else begin : g_index
      always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
          if (req[i]) begin
            hit = 1'b1;
            idx = IW'(i);
          end
        end
      end
    end
  endgenerate

  a_r6_winner_is_req: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req[idx]);

  a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (req == '0));

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [6:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [63:0]     src_i,
  output logic            irq_norm_o,
  output logic            irq_fast_o
);
  localparam int IW  = $clog2(NSRC);
  localparam int NPR = NSRC * PW / DW;
  localparam int PRW = $clog2(NPR);
  localparam int HW  = DW / 2;

  logic [1:0]          rst_sync;
  logic                rst_s;
  bus_req_t            req;
  logic [NSRC-1:0]     en_q, ty_q, fr_q, eff, lvl_ok, np, fp;
  logic [NSRC*PW-1:0]  pr_q;
  logic [PW:0]         lvl_q;
  logic [DW-1:0]       ctl_q, nvec, fvec;
  logic                n_hit, f_hit;
  logic [IW-1:0]       n_idx, f_idx;
  logic [6:0]          pr_off;
  logic [PRW-1:0]      pr_x;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

  vec_intc_regs #(.NSRC(NSRC), .PW(PW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_s),
    .req   (req),
    .en_q  (en_q),
    .ty_q  (ty_q),
    .fr_q  (fr_q),
    .pr_q  (pr_q),
    .lvl_q (lvl_q),
    .ctl_q (ctl_q)
  );

  // per-source qualification against the mask level
  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign lvl_ok[i] = lvl_q[PW] | (pr_q[i*PW +: PW] > lvl_q[PW-1:0]);
  end

  assign eff = (src_i | fr_q) & en_q;
  assign np  = eff & ~ty_q & lvl_ok;
  assign fp  = eff & ty_q;

  vec_intc_pick #(.NSRC(NSRC), .PW(PW), .MODE(PICK_BY_PRIO)) u_pick_norm (
    .clk (clk), .rst_n (rst_s), .req (np), .pri (pr_q), .hit (n_hit), .idx (n_idx)
  );

  vec_intc_pick #(.NSRC(NSRC), .PW(PW), .MODE(PICK_BY_INDEX)) u_pick_fast (
    .clk (clk), .rst_n (rst_s), .req (fp), .pri (pr_q), .hit (f_hit), .idx (f_idx)
  );

  assign nvec = {(n_hit ? {{(HW-IW){1'b0}}, n_idx} : {HW{1'b1}}), {HW{1'b0}}};
  assign fvec = {(f_hit ? {{(HW-IW){1'b0}}, f_idx} : {HW{1'b1}}), {HW{1'b0}}};

  assign irq_norm_o = |np;
  assign irq_fast_o = |fp;

  assign pr_off = bus_addr - A_PRI0;
  assign pr_x   = PRW'(NPR - 1) - pr_off[PRW+1:2];

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:  bus_rdata = ctl_q;
      A_LVL:  bus_rdata = {{(DW-PW-1){1'b0}}, lvl_q};
      A_ENH:  bus_rdata = en_q[DW +: DW];
      A_ENL:  bus_rdata = en_q[0  +: DW];
      A_TYH:  bus_rdata = ty_q[DW +: DW];
      A_TYL:  bus_rdata = ty_q[0  +: DW];
      A_NVEC: bus_rdata = nvec;
      A_FVEC: bus_rdata = fvec;
      A_RAWH: bus_rdata = src_i[DW +: DW];
      A_RAWL: bus_rdata = src_i[0  +: DW];
      A_FRCH: bus_rdata = fr_q[DW +: DW];
      A_FRCL: bus_rdata = fr_q[0  +: DW];
      A_NPH:  bus_rdata = np[DW +: DW];
      A_NPL:  bus_rdata = np[0  +: DW];
      A_FPH:  bus_rdata = fp[DW +: DW];
      A_FPL:  bus_rdata = fp[0  +: DW];
      default: begin
        if (bus_addr >= A_PRI0 && bus_addr <= A_PRIN && bus_addr[1:0] == 2'b00)
          bus_rdata = pr_q[pr_x*DW +: DW];
      end
    endcase
  end

  a_r9_norm_line_vs_vector: assert property (@(posedge clk) disable iff (!rst_s)
    irq_norm_o == (nvec[DW-1:HW] != {HW{1'b1}}));

  a_r9_fast_line_vs_vector: assert property (@(posedge clk) disable iff (!rst_s)
    irq_fast_o == (fvec[DW-1:HW] != {HW{1'b1}}));

  a_r7_winner_above_level: assert property (@(posedge clk) disable iff (!rst_s)
    (n_hit && !lvl_q[PW]) |-> (pr_q[n_idx*PW +: PW] > lvl_q[PW-1:0]));

  a_r2_winner_enabled: assert property (@(posedge clk) disable iff (!rst_s)
    n_hit |-> (en_q[n_idx] && !ty_q[n_idx]));

endmodule

// File: tb/vec_intc_test.sv
module vec_intc_test;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] src_i;
  logic        irq_norm_o, irq_fast_o;

  int nchk, nfail;
  bit done;

  logic [63:0] m_en, m_ty, m_fr;
  logic [31:0] m_pr [8];
  logic [4:0]  m_lvl;
  logic [31:0] m_ctl;

  vec_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  task automatic model_wr(input logic [6:0] a, input logic [31:0] d);
    case (a)
      7'h00: m_ctl = d;
      7'h04: m_lvl = d[4:0];
      7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
      7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
      7'h10: m_en[63:32] = d;
      7'h14: m_en[31:0]  = d;
      7'h18: m_ty[63:32] = d;
      7'h1C: m_ty[31:0]  = d;
      7'h50: m_fr[63:32] = d;
      7'h54: m_fr[31:0]  = d;
      default: if (a >= 7'h20 && a <= 7'h3C) m_pr[7 - ((a - 7'h20) >> 2)] = d;
    endcase
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [3:0] prio_of(input int i);
    return m_pr[i / 8][(i % 8) * 4 +: 4];
  endfunction

  function automatic logic [63:0] exp_np();
    logic [63:0] e = (src_i | m_fr) & m_en & ~m_ty;
    for (int i = 0; i < 64; i++)
      if (!m_lvl[4] && prio_of(i) <= m_lvl[3:0]) e[i] = 1'b0;
    return e;
  endfunction

  function automatic logic [63:0] exp_fp();
    return (src_i | m_fr) & m_en & m_ty;
  endfunction

  function automatic logic [31:0] exp_nvec();
    logic [63:0] p = exp_np();
    int best = -1;
    logic [3:0] bp = 0;
    for (int i = 0; i < 64; i++)
      if (p[i] && (best < 0 || prio_of(i) >= bp)) begin best = i; bp = prio_of(i); end
    return (best < 0) ? 32'hFFFF0000 : {16'(best), 16'h0};
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] p = exp_fp();
    int best = -1;
    for (int i = 0; i < 64; i++) if (p[i]) best = i;
    return (best < 0) ? 32'hFFFF0000 : {16'(best), 16'h0};
  endfunction

  task automatic check_all();
    logic [31:0] d;
    rd(7'h58, d); chk("R2 npend hi", d, exp_np()  >> 32);
    rd(7'h5C, d); chk("R2 npend lo", d, exp_np()  & 64'hFFFFFFFF);
    rd(7'h60, d); chk("R2 fpend hi", d, exp_fp()  >> 32);
    rd(7'h64, d); chk("R2 fpend lo", d, exp_fp()  & 64'hFFFFFFFF);
    rd(7'h40, d); chk("R6 nvec", d, exp_nvec());
    rd(7'h44, d); chk("R8 fvec", d, exp_fvec());
    rd(7'h48, d); chk("R3 raw hi", d, src_i[63:32]);
    rd(7'h4C, d); chk("R3 raw lo", d, src_i[31:0]);
    rd(7'h14, d); chk("R4 en lo", d, m_en[31:0]);
    rd(7'h10, d); chk("R4 en hi", d, m_en[63:32]);
    chk("R9 irq_norm", {31'b0, irq_norm_o}, {31'b0, exp_np() != 0});
    chk("R9 irq_fast", {31'b0, irq_fast_o}, {31'b0, exp_fp() != 0});
  endtask

  logic [6:0] wr_list [14] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18,
                               7'h1C, 7'h50, 7'h54, 7'h20, 7'h2C, 7'h38, 7'h3C};

  initial begin
    logic [31:0] d;
    done = 0; nchk = 0; nfail = 0;
    void'($urandom(32'd20240611));
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; src_i = '0;
    m_en = '0; m_ty = '0; m_fr = '0; m_lvl = 5'h1F; m_ctl = '0;
    for (int i = 0; i < 8; i++) m_pr[i] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset values
    rd(7'h00, d); chk("R1 ctl", d, 32'h0);
    rd(7'h04, d); chk("R1 lvl", d, 32'h1F);
    rd(7'h10, d); chk("R1 en hi", d, 32'h0);
    rd(7'h1C, d); chk("R1 type lo", d, 32'h0);
    rd(7'h54, d); chk("R1 force lo", d, 32'h0);
    rd(7'h24, d); chk("R1 prio", d, 32'h0);
    rd(7'h40, d); chk("R1 nvec", d, 32'hFFFF0000);
    rd(7'h44, d); chk("R1 fvec", d, 32'hFFFF0000);
    chk("R1 irq lines", {30'b0, irq_norm_o, irq_fast_o}, 32'h0);

    // R11 control storage
    wr(7'h00, 32'hA5A55A5A); rd(7'h00, d); chk("R11 ctl", d, 32'hA5A55A5A);

    // R4 by-number, out-of-range ignored
    wr(7'h08, 32'd64);  rd(7'h14, d); chk("R4 oob set lo", d, 32'h0);
    rd(7'h10, d); chk("R4 oob set hi", d, 32'h0);
    wr(7'h08, 32'd63);  rd(7'h10, d); chk("R4 set 63", d, 32'h80000000);
    wr(7'h08, 32'd0);   rd(7'h14, d); chk("R4 set 0", d, 32'h00000001);
    wr(7'h0C, 32'd200); rd(7'h10, d); chk("R4 oob clr", d, 32'h80000000);
    wr(7'h0C, 32'd63);  rd(7'h10, d); chk("R4 clr 63", d, 32'h0);
    rd(7'h08, d); chk("R4 setnum reads 0", d, 32'h0);
    wr(7'h0C, 32'd0);

    // R3 raw visible while disabled
    src_i = 64'hDEAD_BEEF_0123_4567;
    rd(7'h48, d); chk("R3 raw hi", d, 32'hDEADBEEF);
    rd(7'h40, d); chk("R3 disabled nvec", d, 32'hFFFF0000);

    // R5/R6 priority placement and tie break
    src_i = 64'h22;
    wr(7'h14, 32'h22);
    wr(7'h3C, 32'h000000F0);
    rd(7'h40, d); chk("R5 src1 prio15 wins", d, 32'h00010000);
    wr(7'h3C, 32'h0);
    rd(7'h40, d); chk("R6 tie highest num", d, 32'h00050000);
    wr(7'h20, 32'h30000000);
    wr(7'h08, 32'd63);
    src_i[63] = 1'b1;
    rd(7'h40, d); chk("R5 src63 from top reg", d, 32'h003F0000);

    // R7 mask level
    wr(7'h04, 32'h2);
    rd(7'h40, d); chk("R7 lvl2 nvec", d, 32'h003F0000);
    rd(7'h5C, d); chk("R7 lvl2 npend lo", d, 32'h0);
    wr(7'h04, 32'h3);
    rd(7'h40, d); chk("R7 lvl3 nvec", d, 32'hFFFF0000);
    chk("R7 lvl3 irq_norm", {31'b0, irq_norm_o}, 32'h0);
    wr(7'h04, 32'h1F);

    // R8/R2 routing to fast path
    wr(7'h1C, 32'h20);
    rd(7'h44, d); chk("R8 fvec src5", d, 32'h00050000);
    rd(7'h64, d); chk("R2 fpend lo", d, 32'h20);
    rd(7'h5C, d); chk("R2 npend lo", d, 32'h02);
    chk("R9 fast line", {31'b0, irq_fast_o}, 32'h1);

    // R2 force
    src_i = '0;
    wr(7'h54, 32'h2);
    rd(7'h5C, d); chk("R2 forced src1", d, 32'h2);

    // R10 write lands at the edge
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 7'h0C; bus_wdata = 32'd1;
    #2 chk("R10 before edge", {31'b0, irq_norm_o}, 32'h1);
    @(posedge clk); #2;
    chk("R10 after edge", {31'b0, irq_norm_o}, 32'h0);
    bus_sel = 0; bus_wr = 0;
    model_wr(7'h0C, 32'd1);
    check_all();

    // random mix, input changes in the same cycle as writes
    for (int it = 0; it < 400; it++) begin
      logic [6:0]  a = wr_list[$urandom_range(0, 13)];
      logic [31:0] v = $urandom;
      if (a == 7'h08 || a == 7'h0C) v = $urandom_range(0, 79);
      if (a == 7'h04) v = $urandom_range(0, 31);
      @(negedge clk);
      src_i = {$urandom, $urandom} & {$urandom, $urandom};
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
      model_wr(a, v);
      check_all();
    end

    finish_run();
  end
endmodule